// File: doc/BRIEF.md
# Accumulator Arithmetic and Logic Unit with Condition Flags

This block is the arithmetic and logic datapath of a small accumulator-based processor. It is purely combinational. In one evaluation it takes four inputs: a 5-bit operation code, the accumulator byte, a second operand byte and the current condition flags. It returns a result byte, a new flag byte and a write-enable that tells the register path whether to store the result. Fetch, decode, the register file, memory and cycle timing live elsewhere.

There are four condition flags: zero (Z), subtract (N), half-carry (H) and carry (C). Each operation has its own rule for every flag. A flag may be computed, forced to 0, forced to 1, or copied through from the input. The half-carry flag is the carry or borrow across the nibble boundary. Decimal adjust reads the stored N, H and C flags to correct a packed two-digit BCD sum or difference.

Top module: `acc_alu`

## Requirements
- R1: `flags_o` is a byte with Z in bit 7, N in bit 6, H in bit 5 and C in bit 4. Bits 3..0 are always 0. `flags_i` is the nibble {Z,N,H,C} with Z in bit 3 and C in bit 0.
- R2: Codes 18 to 31 are unassigned. For these codes `res_o` equals `acc_i`, the flags pass through unchanged and `wr_en_o` is 0.
- R3: ADD (code 0) computes acc+opnd. ADC (code 1) computes acc+opnd+C_in. Z is set when the result is zero, H is the carry out of bit 3, C is the carry out of bit 7, and N is 0. The incoming C is added into both the nibble sum and the byte sum.
- R4: SUB (code 2) computes acc-opnd. SBC (code 3) computes acc-opnd-C_in. Z is computed, H is the borrow out of bit 3, C is the borrow out of bit 7, and N is 1.
- R5: CMP (code 7) produces the same flags as SUB. `res_o` equals `acc_i` and `wr_en_o` is 0.
- R6: AND (code 4), XOR (code 5) and OR (code 6) compute Z from the result and clear N and C. AND forces H to 1; XOR and OR clear H.
- R7: INC (code 8) returns opnd+1 and DEC (code 9) returns opnd-1. Both compute Z, and H is the nibble carry or borrow. N is 0 for INC and 1 for DEC. C is copied from the input.
- R8: DADJ (code 10) corrects the accumulator using the stored flags. With N=0 it adds 0x60 when C=1 or acc>0x99, and then sets C; it adds 0x06 when H=1 or the low nibble is above 9. With N=1 it subtracts 0x60 when C=1 and 0x06 when H=1, and keeps C. In both cases H becomes 0, N is kept and Z is computed.
- R9: CPLA (code 11) returns the bitwise inverse of acc. It sets N and H to 1 and keeps Z and C.
- R10: SETC (code 12) forces C to 1. CPLC (code 13) inverts C. Both clear N and H, keep Z, return acc and have `wr_en_o` 0.
- R11: The accumulator rotates are ROLC (code 14, left circular), ROLT (code 15, left through carry), RORC (code 16, right circular) and RORT (code 17, right through carry). Each forces Z, N and H to 0 and loads C with the bit shifted out. The through-carry forms shift the incoming C into the vacated bit.
- R12: `wr_en_o` is 1 for codes 0 to 6 and 8 to 11, and for codes 14 to 17.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 5 | Operation code (encodings in R2..R11) |
| acc_i | input | 8 | Accumulator value |
| opnd_i | input | 8 | Second operand; also the source for INC/DEC |
| flags_i | input | 4 | Current flags {Z,N,H,C} |
| res_o | output | 8 | Result byte |
| flags_o | output | 8 | New flag byte {Z,N,H,C,0000} |
| wr_en_o | output | 1 | Result should be written back |

## Verification
The block holds no state, so any internal fault shows at the ports in the same evaluation that triggers it. A wrong carry-in polarity in the shared adder, for example, corrupts SBC or DEC at once, for only some operand pairs. For that reason the arithmetic and logic codes are swept over every operand pair, and every other code is swept over every accumulator value with every flag nibble. Known-value spot cases are added, including a decimal adjust after both an addition and a subtraction. A flag rule applied to the wrong code shows as a forced or copied bit where a computed one belongs, so each code is also checked for which flags it leaves untouched.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
    parameter int DATA_W = 8;
    parameter int OP_W   = 5;
    localparam int NIB_W = DATA_W / 2;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 5'd0,  OP_ADC  = 5'd1,  OP_SUB  = 5'd2,  OP_SBC  = 5'd3,
        OP_AND  = 5'd4,  OP_XOR  = 5'd5,  OP_OR   = 5'd6,  OP_CMP  = 5'd7,
        OP_INC  = 5'd8,  OP_DEC  = 5'd9,  OP_DADJ = 5'd10, OP_CPLA = 5'd11,
        OP_SETC = 5'd12, OP_CPLC = 5'd13, OP_ROLC = 5'd14, OP_ROLT = 5'd15,
        OP_RORC = 5'd16, OP_RORT = 5'd17
    } alu_op_e;

    typedef struct packed {
        logic [DATA_W-1:0] res;
        logic              z;
        logic              n;
        logic              h;
        logic              c;
        logic              we;
    } alu_out_t;
endpackage

// File: rtl/acc_alu_addsub.sv
module acc_alu_addsub
    import acc_alu_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    input  logic         sub_i,
    output logic [W-1:0] sum_o,
    output logic         half_o,
    output logic         carry_o
);
    localparam int HW = W / 2;

    logic [W-1:0]  b_eff;
    logic          c_eff;
    logic [HW:0]   lo_d;
    logic [W:0]    full_d;

    always_comb begin
        // Subtraction is a + ~b + !borrow_in; carry out inverts to a borrow.
        b_eff   = sub_i ? ~b_i : b_i;
        c_eff   = sub_i ? ~cin_i : cin_i;
        lo_d    = {1'b0, a_i[HW-1:0]} + {1'b0, b_eff[HW-1:0]} + {{HW{1'b0}}, c_eff};
        full_d  = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, c_eff};
        sum_o   = full_d[W-1:0];
        half_o  = lo_d[HW] ^ sub_i;
        carry_o = full_d[W] ^ sub_i;
    end
endmodule

// File: rtl/acc_alu_decadj.sv
module acc_alu_decadj
    import acc_alu_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [W-1:0] a_i,
    input  logic         n_i,
    input  logic         h_i,
    input  logic         c_i,
    output logic [W-1:0] res_o,
    output logic         c_o
);
    localparam logic [W-1:0] LO_ADJ   = W'(8'h06);
    localparam logic [W-1:0] HI_ADJ   = W'(8'h60);
    localparam logic [W-1:0] HI_LIMIT = W'(8'h99);
    localparam logic [3:0]   LO_LIMIT = 4'd9;

    logic         lo_fix_d;
    logic         hi_fix_d;
    logic [W-1:0] adj_d;

    always_comb begin
        lo_fix_d = n_i ? h_i : (h_i || (a_i[3:0] > LO_LIMIT));
        hi_fix_d = n_i ? c_i : (c_i || (a_i > HI_LIMIT));
        adj_d    = (hi_fix_d ? HI_ADJ : '0) | (lo_fix_d ? LO_ADJ : '0);
        res_o    = n_i ? (a_i - adj_d) : (a_i + adj_d);
        c_o      = n_i ? c_i : hi_fix_d;
    end
endmodule

// File: rtl/acc_alu_rotate.sv
module acc_alu_rotate
    import acc_alu_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [W-1:0] a_i,
    input  logic         cin_i,
    input  logic         left_i,
    input  logic         thru_i,
    output logic [W-1:0] res_o,
    output logic         cout_o
);
    logic feed_d;

    always_comb begin
        feed_d = thru_i ? cin_i : (left_i ? a_i[W-1] : a_i[0]);
        if (left_i) begin
            res_o  = {a_i[W-2:0], feed_d};
            cout_o = a_i[W-1];
        end else begin
            res_o  = {feed_d, a_i[W-1:1]};
            cout_o = a_i[0];
        end
    end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import acc_alu_pkg::*;
(
    input  logic [OP_W-1:0]   op_i,
    input  logic [DATA_W-1:0] acc_i,
    input  logic [DATA_W-1:0] opnd_i,
    input  logic [3:0]        flags_i,
    output logic [DATA_W-1:0] res_o,
    output logic [7:0]        flags_o,
    output logic              wr_en_o
);
    localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

    logic fz, fn, fh, fc;
    assign {fz, fn, fh, fc} = flags_i;

    // shared adder operand selection
    logic [DATA_W-1:0] as_a_d, as_b_d, as_sum;
    logic              as_cin_d, as_sub_d, as_h, as_c;

    always_comb begin
        as_a_d   = acc_i;
        as_b_d   = opnd_i;
        as_cin_d = 1'b0;
        as_sub_d = 1'b0;
        case (op_i)
            OP_ADC:  as_cin_d = fc;
            OP_SUB,
            OP_CMP:  as_sub_d = 1'b1;
            OP_SBC:  begin as_sub_d = 1'b1; as_cin_d = fc; end
            OP_INC:  begin as_a_d = opnd_i; as_b_d = ONE; end
            OP_DEC:  begin as_a_d = opnd_i; as_b_d = ONE; as_sub_d = 1'b1; end
            default: ;
        endcase
    end

    acc_alu_addsub #(.W(DATA_W)) u_addsub (
        .a_i(as_a_d), .b_i(as_b_d), .cin_i(as_cin_d), .sub_i(as_sub_d),
        .sum_o(as_sum), .half_o(as_h), .carry_o(as_c)
    );

    logic [DATA_W-1:0] da_res;
    logic              da_c;
    acc_alu_decadj #(.W(DATA_W)) u_decadj (
        .a_i(acc_i), .n_i(fn), .h_i(fh), .c_i(fc),
        .res_o(da_res), .c_o(da_c)
    );

    logic [DATA_W-1:0] rot_res;
    logic              rot_c;
    logic              rot_left_d, rot_thru_d;
    assign rot_left_d = (op_i == OP_ROLC) || (op_i == OP_ROLT);
    assign rot_thru_d = (op_i == OP_ROLT) || (op_i == OP_RORT);

    acc_alu_rotate #(.W(DATA_W)) u_rotate (
        .a_i(acc_i), .cin_i(fc), .left_i(rot_left_d), .thru_i(rot_thru_d),
        .res_o(rot_res), .cout_o(rot_c)
    );

    alu_out_t out_d;

    always_comb begin
        out_d = '{res: acc_i, z: fz, n: fn, h: fh, c: fc, we: 1'b0};
        case (op_i)
            OP_ADD, OP_ADC: begin
                out_d = '{res: as_sum, z: (as_sum == '0), n: 1'b0, h: as_h, c: as_c, we: 1'b1};
            end
            OP_SUB, OP_SBC: begin
                out_d = '{res: as_sum, z: (as_sum == '0), n: 1'b1, h: as_h, c: as_c, we: 1'b1};
            end
            OP_CMP: begin
                out_d = '{res: acc_i, z: (as_sum == '0), n: 1'b1, h: as_h, c: as_c, we: 1'b0};
            end
            OP_AND: begin
                out_d.res = acc_i & opnd_i;
                out_d.z   = (out_d.res == '0);
                out_d.n   = 1'b0;
                out_d.h   = 1'b1;
                out_d.c   = 1'b0;
                out_d.we  = 1'b1;
            end
            OP_XOR, OP_OR: begin
                out_d.res = (op_i == OP_XOR) ? (acc_i ^ opnd_i) : (acc_i | opnd_i);
                out_d.z   = (out_d.res == '0);
                out_d.n   = 1'b0;
                out_d.h   = 1'b0;
                out_d.c   = 1'b0;
                out_d.we  = 1'b1;
            end
            OP_INC, OP_DEC: begin
                out_d = '{res: as_sum, z: (as_sum == '0), n: (op_i == OP_DEC),
                          h: as_h, c: fc, we: 1'b1};
            end
            OP_DADJ: begin
                out_d = '{res: da_res, z: (da_res == '0), n: fn, h: 1'b0, c: da_c, we: 1'b1};
            end
            OP_CPLA: begin
                out_d = '{res: ~acc_i, z: fz, n: 1'b1, h: 1'b1, c: fc, we: 1'b1};
            end
            OP_SETC, OP_CPLC: begin
                out_d.n = 1'b0;
                out_d.h = 1'b0;
                out_d.c = (op_i == OP_SETC) ? 1'b1 : ~fc;
            end
            OP_ROLC, OP_ROLT, OP_RORC, OP_RORT: begin
                out_d = '{res: rot_res, z: 1'b0, n: 1'b0, h: 1'b0, c: rot_c, we: 1'b1};
            end
            default: ;
        endcase
    end

    assign res_o   = out_d.res;
    assign flags_o = {out_d.z, out_d.n, out_d.h, out_d.c, 4'b0000};
    assign wr_en_o = out_d.we;
endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk
    import acc_alu_pkg::*;
(
    input logic [OP_W-1:0]   op_i,
    input logic [DATA_W-1:0] acc_i,
    input logic [DATA_W-1:0] opnd_i,
    input logic [3:0]        flags_i,
    input logic [DATA_W-1:0] res_o,
    input logic [7:0]        flags_o,
    input logic              wr_en_o
);
    always_comb begin
        assert_low_nibble_zero_R1: assert (flags_o[3:0] == 4'b0000)
            else $error("R1: low flag nibble not zero");
        if (op_i > OP_RORT) begin
            assert_unassigned_passive_R2: assert (!wr_en_o && res_o == acc_i
                                                  && flags_o[7:4] == flags_i)
                else $error("R2: unassigned code not passive");
        end
        if (op_i == OP_ADD || op_i == OP_ADC) begin
            assert_add_n_clear_R3: assert (!flags_o[6])
                else $error("R3: N set after addition");
        end
        if (op_i == OP_SUB || op_i == OP_SBC) begin
            assert_sub_n_set_R4: assert (flags_o[6])
                else $error("R4: N clear after subtraction");
        end
        if (op_i == OP_CMP) begin
            assert_cmp_no_write_R5: assert (!wr_en_o && flags_o[7] == (acc_i == opnd_i))
                else $error("R5: compare wrote or bad Z");
        end
        if (op_i == OP_AND) begin
            assert_and_forced_R6: assert (flags_o[5] && !flags_o[4] && !flags_o[6])
                else $error("R6: AND forced flags wrong");
        end
        if (op_i == OP_INC || op_i == OP_DEC) begin
            assert_incdec_keep_c_R7: assert (flags_o[4] == flags_i[0])
                else $error("R7: INC/DEC touched C");
        end
        if (op_i == OP_DADJ) begin
            assert_dadj_h_n_R8: assert (!flags_o[5] && flags_o[6] == flags_i[2])
                else $error("R8: decimal adjust H/N wrong");
        end
        if (op_i == OP_CPLA) begin
            assert_cpla_invert_R9: assert (res_o == ~acc_i && flags_o[6] && flags_o[5])
                else $error("R9: complement wrong");
        end
        if (op_i == OP_SETC) begin
            assert_setc_carry_R10: assert (flags_o[4] && !wr_en_o)
                else $error("R10: set carry wrong");
        end
        if (op_i >= OP_ROLC && op_i <= OP_RORT) begin
            assert_rotate_flags_R11: assert (flags_o[7:5] == 3'b000 && wr_en_o)
                else $error("R11: rotate flags wrong");
        end
        if (op_i <= OP_OR) begin
            assert_write_enable_R12: assert (wr_en_o)
                else $error("R12: write enable missing");
        end
    end
endmodule

bind acc_alu acc_alu_chk u_chk (
    .op_i(op_i), .acc_i(acc_i), .opnd_i(opnd_i), .flags_i(flags_i),
    .res_o(res_o), .flags_o(flags_o), .wr_en_o(wr_en_o)
);

// File: tb/acc_alu_tb_top.sv
`timescale 1ns/1ps
module acc_alu_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WDOG_CYCLES = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic [4:0] op;
    logic [7:0] acc, opnd, res, flg;
    logic [3:0] fin;
    logic       we;

    acc_alu dut_i (
        .op_i(op), .acc_i(acc), .opnd_i(opnd), .flags_i(fin),
        .res_o(res), .flags_o(flg), .wr_en_o(we)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // reference built from the requirement text: {we, res, flags}
    function automatic logic [16:0] ref_f(input int o, input logic [7:0] a,
                                          input logic [7:0] b, input logic [3:0] f);
        int ia, ib, ic, t;
        logic [7:0] r;
        logic z, n, h, c, w, lo, hi;
        ia = int'(a); ib = int'(b); ic = int'(f[0]);
        z = f[3]; n = f[2]; h = f[1]; c = f[0]; r = a; w = 1'b0;
        case (o)
            0, 1: begin
                if (o == 0) ic = 0;
                t = ia + ib + ic; r = t[7:0];
                h = ((ia % 16) + (ib % 16) + ic) > 15; c = t > 255; n = 0; z = (r == 0); w = 1;
            end
            2, 3, 7: begin
                if (o != 3) ic = 0;
                t = ia - ib - ic;
                h = ((ia % 16) - (ib % 16) - ic) < 0; c = t < 0; n = 1; z = (t[7:0] == 0);
                r = (o == 7) ? a : t[7:0]; w = (o != 7);
            end
            4: begin r = a & b; z = (r == 0); n = 0; h = 1; c = 0; w = 1; end
            5: begin r = a ^ b; z = (r == 0); n = 0; h = 0; c = 0; w = 1; end
            6: begin r = a | b; z = (r == 0); n = 0; h = 0; c = 0; w = 1; end
            8: begin r = b + 8'd1; z = (r == 0); n = 0; h = (b[3:0] == 4'hF); w = 1; end
            9: begin r = b - 8'd1; z = (r == 0); n = 1; h = (b[3:0] == 4'h0); w = 1; end
            10: begin
                if (!n) begin
                    hi = c || (ia > 153); lo = h || ((ia % 16) > 9);
                    t = ia + (hi ? 96 : 0) + (lo ? 6 : 0); c = hi;
                end else begin
                    t = ia - (c ? 96 : 0) - (h ? 6 : 0);
                end
                r = t[7:0]; z = (r == 0); h = 0; w = 1;
            end
            11: begin r = ~a; n = 1; h = 1; w = 1; end
            12: begin c = 1; n = 0; h = 0; end
            13: begin c = ~c; n = 0; h = 0; end
            14: begin r = {a[6:0], a[7]}; c = a[7]; z = 0; n = 0; h = 0; w = 1; end
            15: begin r = {a[6:0], f[0]}; c = a[7]; z = 0; n = 0; h = 0; w = 1; end
            16: begin r = {a[0], a[7:1]}; c = a[0]; z = 0; n = 0; h = 0; w = 1; end
            17: begin r = {f[0], a[7:1]}; c = a[0]; z = 0; n = 0; h = 0; w = 1; end
            default: ;
        endcase
        return {w, r, z, n, h, c, 4'b0000};
    endfunction

    task automatic compare(input string tag, input logic [16:0] exp_v);
        logic [16:0] act;
        act = {we, res, flg};
        n_cmp++;
        if (act !== exp_v) begin
            n_bad++;
            $display("FAIL %s op=%0d acc=%02h opnd=%02h fin=%h: actual we/res/flags=%b/%02h/%02h expected %b/%02h/%02h",
                     tag, op, acc, opnd, fin, act[16], act[15:8], act[7:0],
                     exp_v[16], exp_v[15:8], exp_v[7:0]);
        end
    endtask

    task automatic drive(input int o, input logic [7:0] a, input logic [7:0] b, input logic [3:0] f);
        op = 5'(o); acc = a; opnd = b; fin = f;
        #1;
    endtask

    task automatic spot(input string tag, input int o, input logic [7:0] a, input logic [7:0] b,
                        input logic [3:0] f, input logic [7:0] er, input logic [7:0] ef, input logic ew);
        drive(o, a, b, f);
        compare(tag, {ew, er, ef});
        compare({tag, "-model"}, ref_f(o, a, b, f));
    endtask

    task automatic sweep_binary(input string tag, input int o, input bit both_c);
        for (int a = 0; a < 256; a++) begin
            for (int b = 0; b < 256; b++) begin
                for (int c = 0; c < (both_c ? 2 : 1); c++) begin
                    logic [3:0] f;
                    f = both_c ? {3'(a + b), 1'(c)} : 4'(a ^ b);
                    drive(o, 8'(a), 8'(b), f);
                    compare(tag, ref_f(o, 8'(a), 8'(b), f));
                end
            end
        end
    endtask

    task automatic sweep_unary(input string tag, input int o);
        for (int a = 0; a < 256; a++) begin
            for (int f = 0; f < 16; f++) begin
                drive(o, 8'(a), 8'(255 - a), 4'(f));
                compare(tag, ref_f(o, 8'(a), 8'(255 - a), 4'(f)));
            end
        end
    endtask

    // ---- scenarios ----
    task automatic t_initial_R2;
        spot("R2", 31, 8'h77, 8'h12, 4'hF, 8'h77, 8'hF0, 1'b0);
    endtask

    task automatic t_add_R3;
        spot("R3", 0, 8'h3A, 8'hC6, 4'h0, 8'h00, 8'hB0, 1'b1);
        spot("R3", 1, 8'hE1, 8'h0F, 4'h1, 8'hF1, 8'h20, 1'b1);
        sweep_binary("R3", 0, 1'b0);
        sweep_binary("R3", 1, 1'b1);
    endtask

    task automatic t_sub_R4;
        spot("R4", 2, 8'h3E, 8'h0F, 4'h0, 8'h2F, 8'h60, 1'b1);
        spot("R4", 3, 8'h3B, 8'h2A, 4'h1, 8'h10, 8'h40, 1'b1);
        sweep_binary("R4", 2, 1'b0);
        sweep_binary("R4", 3, 1'b1);
    endtask

    task automatic t_cmp_R5;
        spot("R5", 7, 8'h3C, 8'h40, 4'h0, 8'h3C, 8'h50, 1'b0);
        spot("R5", 7, 8'h3E, 8'h3E, 4'h1, 8'h3E, 8'hC0, 1'b0);
        sweep_binary("R5", 7, 1'b1);
    endtask

    task automatic t_logic_R6;
        spot("R6", 4, 8'h5A, 8'h3F, 4'h0, 8'h1A, 8'h20, 1'b1);
        spot("R6", 5, 8'hFF, 8'hFF, 4'hF, 8'h00, 8'h80, 1'b1);
        spot("R6", 6, 8'h00, 8'h00, 4'h7, 8'h00, 8'h80, 1'b1);
        sweep_binary("R6", 4, 1'b0);
        sweep_binary("R6", 5, 1'b0);
        sweep_binary("R6", 6, 1'b0);
    endtask

    task automatic t_incdec_R7;
        spot("R7", 8, 8'h55, 8'hFF, 4'h1, 8'h00, 8'hB0, 1'b1);
        spot("R7", 9, 8'h55, 8'h01, 4'h0, 8'h00, 8'hC0, 1'b1);
        spot("R7", 9, 8'h55, 8'h10, 4'h1, 8'h0F, 8'h70, 1'b1);
        for (int b = 0; b < 256; b++) begin
            for (int f = 0; f < 16; f++) begin
                drive(8, 8'h00, 8'(b), 4'(f)); compare("R7", ref_f(8, 8'h00, 8'(b), 4'(f)));
                drive(9, 8'hFF, 8'(b), 4'(f)); compare("R7", ref_f(9, 8'hFF, 8'(b), 4'(f)));
            end
        end
    endtask

    task automatic t_decadj_R8;
        spot("R8", 10, 8'h7D, 8'h00, 4'h0, 8'h83, 8'h00, 1'b1);
        spot("R8", 10, 8'h4B, 8'h00, 4'h6, 8'h45, 8'h40, 1'b1);
        spot("R8", 10, 8'h9A, 8'h00, 4'h0, 8'h00, 8'h90, 1'b1);
        sweep_unary("R8", 10);
    endtask

    task automatic t_cpla_R9;
        spot("R9", 11, 8'h35, 8'h00, 4'h9, 8'hCA, 8'hF0, 1'b1);
        sweep_unary("R9", 11);
    endtask

    task automatic t_carry_R10;
        spot("R10", 12, 8'h21, 8'h00, 4'h8, 8'h21, 8'h90, 1'b0);
        spot("R10", 13, 8'h21, 8'h00, 4'h1, 8'h21, 8'h00, 1'b0);
        sweep_unary("R10", 12);
        sweep_unary("R10", 13);
    endtask

    task automatic t_rotate_R11;
        spot("R11", 15, 8'h95, 8'h00, 4'h1, 8'h2B, 8'h10, 1'b1);
        spot("R11", 14, 8'h95, 8'h00, 4'h0, 8'h2B, 8'h10, 1'b1);
        spot("R11", 16, 8'h01, 8'h00, 4'h0, 8'h80, 8'h10, 1'b1);
        spot("R11", 17, 8'h01, 8'h00, 4'hE, 8'h00, 8'h10, 1'b1);
        for (int o = 14; o <= 17; o++) sweep_unary("R11", o);
    endtask

    task automatic t_unassigned_R2;
        for (int o = 18; o < 32; o++) sweep_unary("R2", o);
    endtask

    task automatic t_wren_R12;
        for (int o = 0; o < 18; o++) begin
            drive(o, 8'h5C, 8'hA3, 4'h5);
            n_cmp++;
            if (we !== ((o != 7) && (o != 12) && (o != 13))) begin
                n_bad++;
                $display("FAIL R12 op=%0d: actual wr_en=%b expected %b", o, we,
                         (o != 7) && (o != 12) && (o != 13));
            end
        end
    endtask

    task automatic t_flag_layout_R1;
        for (int o = 0; o < 32; o++) begin
            drive(o, 8'hC3, 8'h3C, 4'hF);
            n_cmp++;
            if (flg[3:0] !== 4'b0000) begin
                n_bad++;
                $display("FAIL R1 op=%0d: actual low nibble=%h expected 0", o, flg[3:0]);
            end
        end
    endtask

    initial begin
        op = '0; acc = '0; opnd = '0; fin = '0;
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_initial_R2();
        t_flag_layout_R1();
        t_add_R3();
        t_sub_R4();
        t_cmp_R5();
        t_logic_R6();
        t_incdec_R7();
        t_decadj_R8();
        t_cpla_R9();
        t_carry_R10();
        t_rotate_R11();
        t_unassigned_R2();
        t_wren_R12();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (WDOG_CYCLES) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual run still busy expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule